// File: doc/BRIEF.md
# Zero-Operand Stack Execution Core

This core executes a tiny instruction stream for a machine that has no operand registers at all. Every value that is computed lives on an internal stack. Instructions arrive one at a time over a valid/ready handshake. Each one carries a 2-bit operation code and a 16-bit data-memory address. A push copies a word from data memory onto the stack. A pop copies the top word back out to memory. An add combines the two topmost words and leaves a single result on the stack. Data memory is reached through one synchronous port, and a read returns its data on the clock edge after the address is presented.

The stack holds 16 words. Its top is tracked by a byte-addressed pointer that moves in steps of 4 and reads 0 when the stack is empty. Two sticky flags record any attempt to take more from the stack than it holds, or to put more on it than it can hold. Such a faulty instruction is consumed without changing the pointer, the stack or memory. A statement such as A = B + C maps onto push C, push B, add, pop A.

Top module: `stk_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to its initial state: `top_ptr` = 0, `ovf` = 0, `unf` = 0, and `in_ready` is 1 after the edge.
- R2: Push (opcode 00) on a non-full stack drives `mem_re`=1 and `mem_addr`=`in_addr` in the cycle it is accepted. It holds `in_ready` low for the next cycle, stores `mem_rdata` as the new top entry, and finally reads `top_ptr` 4 higher.
- R3: Pop (opcode 01) on a non-empty stack drives `mem_we`=1, `mem_addr`=`in_addr` and `mem_wdata`=top entry in the cycle it is accepted, and `top_ptr` drops by 4 after that edge.
- R4: Add (opcode 10) with at least two entries replaces them with a single entry. That entry holds their sum modulo 2^32, and `top_ptr` drops by 4 in one cycle.
- R5: Entries leave the stack in reverse order of arrival, across all 16 slots.
- R6: Pop on an empty stack, or add with fewer than two entries, sets `unf`. Such an instruction writes no memory and leaves `top_ptr` and the stack contents unchanged.
- R7: Push when 16 entries are held sets `ovf`. It issues no memory read and leaves `top_ptr` (64) and the stack contents unchanged.
- R8: Opcode 11 is a no-op: no memory access, no change to `top_ptr`, stack or flags.
- R9: `ovf` and `unf` stay set until reset, whatever instructions follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Core can accept an instruction this cycle |
| in_op | input | 2 | 00 push, 01 pop, 10 add, 11 no-op |
| in_addr | input | 16 | Data-memory word address for push/pop |
| mem_addr | output | 16 | Data-memory address |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| top_ptr | output | 7 | Byte-addressed top pointer, 0 when empty, step 4 |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
A wrong top pointer shows up on `top_ptr` one cycle after the instruction that moved it, or two cycles after a push. A corrupted or misplaced stack entry stays hidden until a later pop drives it onto `mem_wdata`. That can be many instructions later, so the bench drains the full stack and compares every popped word and address in order. A faulty instruction that wrongly touches memory is caught in that same cycle by the write monitor and the read counter.

// File: rtl/stk_core.sv
module stk_core #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH*4+1),
  localparam int CW   = $clog2(DEPTH+1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [PW-1:0] top_ptr,
  output logic          ovf,
  output logic          unf
);
  localparam logic [1:0] OP_PUSH = 2'b00, OP_POP = 2'b01, OP_ADD = 2'b10;

  logic [DW-1:0] stk [DEPTH];
  logic [PW-1:0] top;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [IW-1:0] i_top, i_below, i_new;
  logic          acc, is_push, is_pop, is_add, full, can_pop, can_add;

  assign cnt     = CW'(top >> 2);
  assign i_top   = IW'(cnt - CW'(1));
  assign i_below = IW'(cnt - CW'(2));
  assign i_new   = IW'(cnt);
  assign full    = (cnt == CW'(DEPTH));
  assign can_pop = (cnt != '0);
  assign can_add = (cnt >= CW'(2));

  assign in_ready = ~busy;
  assign acc      = in_valid & ~busy;
  assign is_push  = acc & (in_op == OP_PUSH);
  assign is_pop   = acc & (in_op == OP_POP);
  assign is_add   = acc & (in_op == OP_ADD);

  assign mem_addr  = in_addr;
  assign mem_re    = is_push & ~full;
  assign mem_we    = is_pop & can_pop;
  assign mem_wdata = stk[i_top];
  assign top_ptr   = top;

  always_ff @(posedge clk) begin
    if (rst) begin
      top  <= '0;
      busy <= 1'b0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else if (busy) begin
      top  <= top + PW'(4);
      busy <= 1'b0;
    end else begin
      if (mem_re) busy <= 1'b1;
      if (is_push & full) ovf <= 1'b1;
      if (mem_we) top <= top - PW'(4);
      if (is_pop & ~can_pop) unf <= 1'b1;
      if (is_add) begin
        if (can_add) top <= top - PW'(4);
        else unf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && busy) stk[i_new] <= mem_rdata;
    else if (!rst && is_add && can_add) stk[i_below] <= stk[i_top] + stk[i_below];
  end

  // R2: push finishes with the pointer one word higher
  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!in_ready ##1 (top_ptr == $past(top_ptr, 2) + PW'(4))));
  // R3: a memory write always retires one stack word
  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (top_ptr == $past(top_ptr) - PW'(4)));
  // R7: pointer stays word-aligned and within the stack
  a_r7_bound: assert property (@(posedge clk) disable iff (rst)
    (top_ptr <= PW'(DEPTH*4)) && (top_ptr[1:0] == 2'b00));
  // R9: flags are sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst) unf |=> unf);
  // R6: an empty stack never drives a memory write
  a_r6_no_empty_write: assert property (@(posedge clk) disable iff (rst)
    (top_ptr == '0) |-> !mem_we);
  // R8: at most one memory access per cycle
  a_r8_one_access: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we));
endmodule

// File: tb/sim_stk_core.sv
module sim_stk_core;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_op = 2'b11;
  logic [15:0] in_addr = '0, mem_addr;
  logic mem_re, mem_we, ovf, unf;
  logic [31:0] mem_rdata, mem_wdata;
  logic [6:0] top_ptr;

  always #5 clk = ~clk;

  stk_core u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .top_ptr(top_ptr), .ovf(ovf), .unf(unf));

  logic [31:0] mem [64];
  int vectors = 0, errors = 0, reads = 0, exp_top = 0;
  logic [47:0] wq [$];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_re) begin mem_rdata <= mem[mem_addr[5:0]]; reads++; end
  end

  // monitor: every write must match the next expected write
  always @(posedge clk) if (!rst && mem_we) begin
    vectors++;
    if (wq.size() == 0) begin
      errors++;
      $display("FAIL R3/R6 unexpected write addr=%0d data=%h expected none", mem_addr, mem_wdata);
    end else begin
      logic [47:0] e;
      e = wq.pop_front();
      if ({mem_addr, mem_wdata} !== e) begin
        errors++;
        $display("FAIL R3/R5 write got %h:%h expected %h:%h", mem_addr, mem_wdata, e[47:32], e[31:0]);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0; in_op = 2'b11;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] a);
    int r0;
    r0 = reads;
    issue(2'b00, a);
    exp_top += 4;
    check("R2 read count", reads, r0 + 1);
    check("R2 top", top_ptr, exp_top);
  endtask

  task automatic pop(input logic [15:0] a, input logic [31:0] d);
    wq.push_back({a, d});
    issue(2'b01, a);
    exp_top -= 4;
    check("R3 top", top_ptr, exp_top);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_top = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none
    for (int i = 0; i < 64; i++) mem[i] = 32'h100 + i;
    mem[2] = 5; mem[3] = 7; mem[4] = 32'hFFFF_FFFF; mem[5] = 2;
    do_reset();
    @(negedge clk);
    check("R1 top", top_ptr, 0);
    check("R1 flags", {ovf, unf}, 0);
    check("R1 ready", in_ready, 1);

    // A = B + C : push C, push B, add, pop A
    push(3); push(2);
    issue(2'b10, 0); exp_top -= 4;
    check("R4 top after add", top_ptr, exp_top);
    pop(1, 12);
    @(negedge clk);
    check("R4 result in memory", mem[1], 12);

    // wraparound sum
    push(4); push(5);
    issue(2'b10, 0); exp_top -= 4;
    pop(6, 32'h1);

    // R8 no-op
    push(7);
    begin
      int r0; r0 = reads;
      issue(2'b11, 9);
      check("R8 top", top_ptr, exp_top);
      check("R8 reads", reads, r0);
      check("R8 flags", {ovf, unf}, 0);
    end
    // R6 add with one entry
    issue(2'b10, 0);
    check("R6 unf on short add", unf, 1);
    check("R6 top kept", top_ptr, exp_top);
    pop(8, 32'h107);
    // R6 pop on empty
    issue(2'b01, 9);
    check("R6 top kept empty", top_ptr, 0);
    push(2);
    check("R9 unf sticky", unf, 1);
    pop(9, 5);

    do_reset();
    @(negedge clk);
    check("R1 flags cleared", {ovf, unf}, 0);

    // R5/R7 fill, overflow, drain
    for (int i = 0; i < 16; i++) push(16'(10 + i));
    begin
      int r0; r0 = reads;
      issue(2'b00, 40);
      check("R7 ovf", ovf, 1);
      check("R7 no read", reads, r0);
      check("R7 top", top_ptr, 64);
    end
    issue(2'b11, 0);
    check("R9 ovf sticky", ovf, 1);
    for (int i = 15; i >= 0; i--) pop(16'(40 + i), 32'h100 + 32'(10 + i));
    @(negedge clk);
    check("R5 all writes seen", wq.size(), 0);
    check("R5 last slot", mem[40], 32'h10A);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule